// File: doc/BRIEF.md
# Local Bus Target Address Decoder

This block is the target side of a 486-style local bus with 32-bit address and data paths. When the address strobe is sampled low, the block checks the address against a base that can be moved by strap pins. If the address falls inside one of five windows, the block claims the cycle: frame memory, a mapped-I/O window, eight port registers, a 2 KB TV buffer or the coprocessor registers. It asserts the active-low device select, counts a fixed number of wait states and then ends the cycle with a one-clock local-ready pulse. If the address falls outside every window, the block stays silent so that another target can respond.

Downstream register files see a one-hot region select, a dword offset inside the region, a write flag, byte-lane enables and a one-clock request strobe. For a mapped-I/O read, address bits 13:12 choose the byte lane that is returned, and the bus byte enables are not used. Read data comes back on the same clock as local ready. Both shared handshake lines are driven high for one clock after the cycle and are then released.

Top module: `lbus_target_dec`

## Requirements
- R1: While `rst` is high, every output enable is 0, `ldev_n_o` and `lrdy_n_o` are 1, and the strap inputs are captured on each clock. After reset the captured strap values are held.
- R2: A hit requires addr[31:30]=00, addr[25:24]=00 and addr[29:26] equal to the captured 4-bit base strap. With base 0101 the upper address byte is 14h.
- R3: The block claims cycles only when the captured 3-bit mode strap is 101 (linear addressing). Every other code, including 100, means that no cycle is ever claimed.
- R4: addr[23:20]=0000 or 0001 selects frame memory (region bit 0), with offset = addr[20:2]. addr[1:0] is don't-care.
- R5: addr[23:16]=80h selects mapped I/O (region bit 1), with offset = addr[15:2]. A read sets req_be_o to the one-hot lane addr[13:12], and only that byte of read data is returned (other lanes zero). A write passes the inverted bus byte enables, and addr[13:12] does not affect them.
- R6: addr[23:17]=1000101 with addr[1:0]=00 opens the register space, and addr[16] is don't-care. Inside it: addr[15:13]=110 selects ports (region bit 2, offset addr[12:2]). addr[15:12]=1110 selects the TV window (region bit 3, offset addr[10:2], bit 11 ignored). addr[15:12]=1111 selects the coprocessor registers (region bit 4, offset addr[11:2]). Nonzero addr[1:0] is a miss.
- R7: On a miss, ldev_n_o, lrdy_n_o and their output enables stay inactive, region_sel_o stays 0, and the block accepts the next strobe at once.
- R8: On a hit sampled at edge k, ldev_n_o is low from edge k. lrdy_n_o is low for exactly one clock from edge k+WAIT_STATES.
- R9: For a read, dat_oe_o is 1 only during the ready clock, and dat_o holds the returned data. For a write, dat_oe_o stays 0.
- R10: In the clock after ready, ldev_n_o and lrdy_n_o are driven high with their enables set. One clock later both enables are 0.
- R11: After a claimed cycle, a new strobe is ignored until rdyrtn_n_i has been sampled low at or after the ready clock.
- R12: req_stb_o pulses for one clock at the claim. region_sel_o, region_off_o, req_wr_o and req_be_o hold their values until release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_base_i | input | 4 | Base relocation strap (pulled low) |
| strap_mode_i | input | 3 | Bus-type strap |
| ads_n_i | input | 1 | Address strobe, active low |
| addr_i | input | 32 | Byte address |
| wr_i | input | 1 | 1 = write, 0 = read |
| be_n_i | input | 4 | Bus byte enables, active low |
| rdyrtn_n_i | input | 1 | Ready return from the bus, active low |
| ldev_n_o | output | 1 | Device select, active low |
| ldev_oe_o | output | 1 | Drive enable for device select |
| lrdy_n_o | output | 1 | Local ready, active low |
| lrdy_oe_o | output | 1 | Drive enable for local ready |
| dat_o | output | 32 | Read data to the bus |
| dat_oe_o | output | 1 | Drive enable for the data bus |
| rd_data_i | input | 32 | Read data from the selected register file |
| region_sel_o | output | 5 | One-hot region: 0 frame, 1 mapped I/O, 2 port, 3 TV, 4 coprocessor |
| region_off_o | output | 19 | Dword offset within the region |
| req_wr_o | output | 1 | Write qualifier |
| req_be_o | output | 4 | Active-high byte lanes for the request |
| req_stb_o | output | 1 | One-clock request pulse at claim |

## Verification
The bound checker watches the cycle shape on every clock. It checks that the region select is one-hot, that device select is never low undriven or without a region, that ready lasts a single clock and is followed by the drive-high and release clocks, that data is driven only in a read's ready clock, that the request strobe lasts one clock, and that outputs are quiet during reset. The address map cannot be seen cycle by cycle, so the bench's scenarios cover it. These include the strap-dependent base, the mode strap, each region's offset, lane selection in the mapped-I/O window, misses from stray base bits or misaligned register addresses, and a strobe ignored while ready-return is still pending.

// File: rtl/lbt_pkg.sv
`timescale 1ns/1ps
package lbt_pkg;
  localparam int ADDR_W  = 32;
  localparam int DATA_W  = 32;
  localparam int BE_W    = DATA_W / 8;
  localparam int STRAP_W = 4;
  localparam int MODE_W  = 3;
  localparam int OFF_W   = 19;
  localparam int NREG    = 5;
  localparam logic [MODE_W-1:0] MODE_LINEAR = 3'b101;

  typedef enum int unsigned {
    RG_FRAME = 0,
    RG_MIO   = 1,
    RG_PORT  = 2,
    RG_TV    = 3,
    RG_COP   = 4
  } region_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_RDY, ST_PARK, ST_HOLD
  } cyc_state_e;
endpackage

// File: rtl/lbt_strap_latch.sv
`timescale 1ns/1ps
module lbt_strap_latch
  import lbt_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [STRAP_W-1:0] strap_base_i,
  input  logic [MODE_W-1:0]  strap_mode_i,
  output logic [STRAP_W-1:0] base_o,
  output logic               linear_o
);
  // Straps follow the pins throughout reset and freeze when it ends.
  always_ff @(posedge clk) begin
    if (rst) begin
      base_o   <= strap_base_i;
      linear_o <= (strap_mode_i == MODE_LINEAR);
    end
  end
endmodule

// File: rtl/lbt_addr_decode.sv
`timescale 1ns/1ps
module lbt_addr_decode
  import lbt_pkg::*;
(
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic               wr_i,
  input  logic [BE_W-1:0]    be_n_i,
  input  logic [STRAP_W-1:0] base_i,
  input  logic               linear_i,
  output logic               hit_o,
  output logic [NREG-1:0]    sel_o,
  output logic [OFF_W-1:0]   off_o,
  output logic [BE_W-1:0]    be_o
);
  logic upper_ok;
  logic reg_space;

  always_comb begin
    upper_ok  = linear_i && (addr_i[31:30] == 2'b00) && (addr_i[25:24] == 2'b00)
                && (addr_i[29:26] == base_i);
    reg_space = (addr_i[23:17] == 7'b1000101) && (addr_i[1:0] == 2'b00);
    sel_o = '0;
    off_o = '0;
    be_o  = ~be_n_i;
    if (upper_ok) begin
      if (addr_i[23:21] == 3'b000) begin
        sel_o[RG_FRAME] = 1'b1;
        off_o = addr_i[20:2];
      end else if (addr_i[23:16] == 8'h80) begin
        sel_o[RG_MIO] = 1'b1;
        off_o = OFF_W'(addr_i[15:2]);
        if (!wr_i) be_o = BE_W'(1) << addr_i[13:12];
      end else if (reg_space) begin
        if (addr_i[15:13] == 3'b110) begin
          sel_o[RG_PORT] = 1'b1;
          off_o = OFF_W'(addr_i[12:2]);
        end else if (addr_i[15:12] == 4'b1110) begin
          sel_o[RG_TV] = 1'b1;
          off_o = OFF_W'(addr_i[10:2]);
        end else if (addr_i[15:12] == 4'b1111) begin
          sel_o[RG_COP] = 1'b1;
          off_o = OFF_W'(addr_i[11:2]);
        end
      end
    end
    hit_o = |sel_o;
  end
endmodule

// File: rtl/lbt_cycle_ctrl.sv
`timescale 1ns/1ps
module lbt_cycle_ctrl
  import lbt_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ads_n_i,
  input  logic              rdyrtn_n_i,
  input  logic              hit_i,
  input  logic [NREG-1:0]   sel_i,
  input  logic [OFF_W-1:0]  off_i,
  input  logic              wr_i,
  input  logic [BE_W-1:0]   be_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              ldev_n_o,
  output logic              ldev_oe_o,
  output logic              lrdy_n_o,
  output logic              lrdy_oe_o,
  output logic [DATA_W-1:0] dat_o,
  output logic              dat_oe_o,
  output logic [NREG-1:0]   sel_o,
  output logic [OFF_W-1:0]  off_o,
  output logic              wr_o,
  output logic [BE_W-1:0]   be_o,
  output logic              stb_o
);
  localparam int CNT_W = $clog2(WAIT_STATES + 1);

  cyc_state_e        state;
  logic [CNT_W-1:0]  cnt;
  logic              rtn_seen;
  logic [DATA_W-1:0] lane_mask;
  logic [DATA_W-1:0] rd_shaped;

  for (genvar b = 0; b < BE_W; b++) begin : g_lane
    assign lane_mask[b*8 +: 8] = {8{be_o[b]}};
  end

  assign rd_shaped = sel_o[RG_MIO] ? (rd_data_i & lane_mask) : rd_data_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      rtn_seen  <= 1'b0;
      ldev_n_o  <= 1'b1;
      ldev_oe_o <= 1'b0;
      lrdy_n_o  <= 1'b1;
      lrdy_oe_o <= 1'b0;
      dat_o     <= '0;
      dat_oe_o  <= 1'b0;
      sel_o     <= '0;
      off_o     <= '0;
      wr_o      <= 1'b0;
      be_o      <= '0;
      stb_o     <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!ads_n_i && hit_i) begin
            state     <= ST_WAIT;
            cnt       <= CNT_W'(WAIT_STATES);
            rtn_seen  <= 1'b0;
            ldev_n_o  <= 1'b0;
            ldev_oe_o <= 1'b1;
            lrdy_n_o  <= 1'b1;
            lrdy_oe_o <= 1'b1;
            sel_o     <= sel_i;
            off_o     <= off_i;
            wr_o      <= wr_i;
            be_o      <= be_i;
            stb_o     <= 1'b1;
          end
        end
        ST_WAIT: begin
          if (cnt == CNT_W'(1)) begin
            state    <= ST_RDY;
            lrdy_n_o <= 1'b0;
            if (!wr_o) begin
              dat_oe_o <= 1'b1;
              dat_o    <= rd_shaped;
            end
          end else begin
            cnt <= cnt - CNT_W'(1);
          end
        end
        ST_RDY: begin
          state    <= ST_PARK;
          lrdy_n_o <= 1'b1;
          ldev_n_o <= 1'b1;
          dat_oe_o <= 1'b0;
          if (!rdyrtn_n_i) rtn_seen <= 1'b1;
        end
        ST_PARK: begin
          ldev_oe_o <= 1'b0;
          lrdy_oe_o <= 1'b0;
          sel_o     <= '0;
          state     <= (rtn_seen || !rdyrtn_n_i) ? ST_IDLE : ST_HOLD;
        end
        ST_HOLD: begin
          if (!rdyrtn_n_i) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/lbus_target_dec.sv
`timescale 1ns/1ps
module lbus_target_dec
  import lbt_pkg::*;
#(
  parameter int WAIT_STATES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [STRAP_W-1:0]   strap_base_i,
  input  logic [MODE_W-1:0]    strap_mode_i,
  input  logic                 ads_n_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 wr_i,
  input  logic [BE_W-1:0]      be_n_i,
  input  logic                 rdyrtn_n_i,
  output logic                 ldev_n_o,
  output logic                 ldev_oe_o,
  output logic                 lrdy_n_o,
  output logic                 lrdy_oe_o,
  output logic [DATA_W-1:0]    dat_o,
  output logic                 dat_oe_o,
  input  logic [DATA_W-1:0]    rd_data_i,
  output logic [NREG-1:0]      region_sel_o,
  output logic [OFF_W-1:0]     region_off_o,
  output logic                 req_wr_o,
  output logic [BE_W-1:0]      req_be_o,
  output logic                 req_stb_o
);
  logic [STRAP_W-1:0] base;
  logic               linear;
  logic               hit;
  logic [NREG-1:0]    dec_sel;
  logic [OFF_W-1:0]   dec_off;
  logic [BE_W-1:0]    dec_be;

  lbt_strap_latch u_strap (
    .clk(clk), .rst(rst), .strap_base_i(strap_base_i), .strap_mode_i(strap_mode_i),
    .base_o(base), .linear_o(linear)
  );

  lbt_addr_decode u_dec (
    .addr_i(addr_i), .wr_i(wr_i), .be_n_i(be_n_i), .base_i(base), .linear_i(linear),
    .hit_o(hit), .sel_o(dec_sel), .off_o(dec_off), .be_o(dec_be)
  );

  lbt_cycle_ctrl #(.WAIT_STATES(WAIT_STATES)) u_cyc (
    .clk(clk), .rst(rst), .ads_n_i(ads_n_i), .rdyrtn_n_i(rdyrtn_n_i),
    .hit_i(hit), .sel_i(dec_sel), .off_i(dec_off), .wr_i(wr_i), .be_i(dec_be),
    .rd_data_i(rd_data_i),
    .ldev_n_o(ldev_n_o), .ldev_oe_o(ldev_oe_o), .lrdy_n_o(lrdy_n_o), .lrdy_oe_o(lrdy_oe_o),
    .dat_o(dat_o), .dat_oe_o(dat_oe_o), .sel_o(region_sel_o), .off_o(region_off_o),
    .wr_o(req_wr_o), .be_o(req_be_o), .stb_o(req_stb_o)
  );
endmodule

// File: rtl/lbt_checker.sv
`timescale 1ns/1ps
module lbt_checker
  import lbt_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            ldev_n_o,
  input logic            ldev_oe_o,
  input logic            lrdy_n_o,
  input logic            lrdy_oe_o,
  input logic            dat_oe_o,
  input logic [NREG-1:0] region_sel_o,
  input logic            req_wr_o,
  input logic            req_stb_o
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: one edge into reset, every output is quiet
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_quiet_r1: assert (!ldev_oe_o && !lrdy_oe_o && !dat_oe_o && ldev_n_o && lrdy_n_o);
    end
  end

  p_region_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(region_sel_o));

  p_claim_has_region_r7: assert property (@(posedge clk) disable iff (rst)
    !ldev_n_o |-> (ldev_oe_o && region_sel_o != '0));

  p_ready_one_clock_r8: assert property (@(posedge clk) disable iff (rst)
    !lrdy_n_o |=> lrdy_n_o);

  p_ready_needs_claim_r8: assert property (@(posedge clk) disable iff (rst)
    !lrdy_n_o |-> (!ldev_n_o && lrdy_oe_o));

  p_data_in_ready_r9: assert property (@(posedge clk) disable iff (rst)
    dat_oe_o |-> (!lrdy_n_o && !req_wr_o));

  p_park_high_r10: assert property (@(posedge clk) disable iff (rst)
    !lrdy_n_o |=> (lrdy_oe_o && ldev_oe_o && ldev_n_o));

  p_release_r10: assert property (@(posedge clk) disable iff (rst)
    !lrdy_n_o |=> ##1 (!lrdy_oe_o && !ldev_oe_o));

  p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    req_stb_o |=> !req_stb_o);
endmodule

bind lbus_target_dec lbt_checker u_chk (
  .clk(clk), .rst(rst), .ldev_n_o(ldev_n_o), .ldev_oe_o(ldev_oe_o),
  .lrdy_n_o(lrdy_n_o), .lrdy_oe_o(lrdy_oe_o), .dat_oe_o(dat_oe_o),
  .region_sel_o(region_sel_o), .req_wr_o(req_wr_o), .req_stb_o(req_stb_o)
);

// File: tb/lbus_target_dec_tb_top.sv
`timescale 1ns/1ps
module lbus_target_dec_tb_top;
  localparam int W = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  strap_base = 4'b0101;
  logic [2:0]  strap_mode = 3'b101;
  logic        ads_n = 1'b1;
  logic [31:0] addr = '0;
  logic        wr = 1'b0;
  logic [3:0]  be_n = 4'hF;
  logic        rdyrtn_n = 1'b1;
  logic [31:0] rd_data = '0;
  logic        ldev_n, ldev_oe, lrdy_n, lrdy_oe, dat_oe, req_wr, req_stb;
  logic [31:0] dat;
  logic [4:0]  region_sel;
  logic [18:0] region_off;
  logic [3:0]  req_be;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  lbus_target_dec #(.WAIT_STATES(W)) dut_i (
    .clk(clk), .rst(rst), .strap_base_i(strap_base), .strap_mode_i(strap_mode),
    .ads_n_i(ads_n), .addr_i(addr), .wr_i(wr), .be_n_i(be_n), .rdyrtn_n_i(rdyrtn_n),
    .ldev_n_o(ldev_n), .ldev_oe_o(ldev_oe), .lrdy_n_o(lrdy_n), .lrdy_oe_o(lrdy_oe),
    .dat_o(dat), .dat_oe_o(dat_oe), .rd_data_i(rd_data),
    .region_sel_o(region_sel), .region_off_o(region_off), .req_wr_o(req_wr),
    .req_be_o(req_be), .req_stb_o(req_stb)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [3:0] sb, input logic [2:0] sm);
    @(negedge clk);
    rst = 1'b1; strap_base = sb; strap_mode = sm;
    repeat (3) @(negedge clk);
    chk(!ldev_oe && !lrdy_oe && !dat_oe, "R1 oe in reset", {29'd0, ldev_oe, lrdy_oe, dat_oe}, 0);
    chk(ldev_n && lrdy_n, "R1 strobes high in reset", {30'd0, ldev_n, lrdy_n}, 3);
    rst = 1'b0;
    strap_base = ~sb;   // R1: later pin changes must not move the base
    strap_mode = 3'b000;
    @(negedge clk);
  endtask

  // One bus access; a hit runs the full handshake, a miss checks silence.
  task automatic access(input string tag, input logic [31:0] a, input bit w, input logic [3:0] ben,
                        input logic [31:0] rdat, input bit exp_hit, input logic [4:0] exp_sel,
                        input logic [18:0] exp_off, input logic [3:0] exp_be, input logic [31:0] exp_dat);
    ads_n = 1'b0; addr = a; wr = w; be_n = ben; rd_data = rdat;
    @(negedge clk);
    ads_n = 1'b1;
    if (!exp_hit) begin
      for (int i = 0; i < W + 2; i++) begin
        chk(ldev_n && lrdy_n && !ldev_oe && !lrdy_oe, {tag, " R7 miss silent"},
            {28'd0, ldev_n, lrdy_n, ldev_oe, lrdy_oe}, 32'hC);
        chk(region_sel == 0, {tag, " R7 no region"}, {27'd0, region_sel}, 0);
        @(negedge clk);
      end
      return;
    end
    chk(!ldev_n && ldev_oe, {tag, " R8 claim"}, {30'd0, ldev_n, ldev_oe}, 1);
    chk(region_sel == exp_sel, {tag, " region"}, {27'd0, region_sel}, {27'd0, exp_sel});
    chk(region_off == exp_off, {tag, " offset"}, {13'd0, region_off}, {13'd0, exp_off});
    chk(req_be == exp_be && req_wr == w, {tag, " be/wr"}, {27'd0, req_wr, req_be}, {27'd0, w, exp_be});
    chk(req_stb, "R12 strobe at claim", {31'd0, req_stb}, 1);
    for (int i = 1; i < W; i++) begin
      @(negedge clk);
      chk(lrdy_n && !req_stb, "R8/R12 waiting", {30'd0, lrdy_n, req_stb}, 2);
    end
    @(negedge clk);
    chk(!lrdy_n, {tag, " R8 ready"}, {31'd0, lrdy_n}, 0);
    chk(dat_oe == !w, {tag, " R9 data enable"}, {31'd0, dat_oe}, {31'd0, !w});
    if (!w) chk(dat == exp_dat, {tag, " read data"}, dat, exp_dat);
    chk(region_sel == exp_sel && region_off == exp_off, "R12 held", {27'd0, region_sel}, {27'd0, exp_sel});
    rdyrtn_n = 1'b0;
    @(negedge clk);
    rdyrtn_n = 1'b1;
    chk(ldev_n && lrdy_n && ldev_oe && lrdy_oe && !dat_oe, "R10 park high",
        {27'd0, ldev_n, lrdy_n, ldev_oe, lrdy_oe, dat_oe}, 32'h1E);
    @(negedge clk);
    chk(!ldev_oe && !lrdy_oe, "R10 release", {30'd0, ldev_oe, lrdy_oe}, 0);
  endtask

  task automatic t_hold;
    // R11: without ready-return, a second strobe is ignored
    ads_n = 1'b0; addr = 32'h1400_0010; wr = 1'b1; be_n = 4'h0;
    @(negedge clk);
    ads_n = 1'b1;
    repeat (W + 2) @(negedge clk);
    ads_n = 1'b0; addr = 32'h1400_0020;
    @(negedge clk);
    ads_n = 1'b1;
    chk(ldev_n && !ldev_oe, "R11 strobe ignored while pending", {30'd0, ldev_n, ldev_oe}, 2);
    rdyrtn_n = 1'b0;
    @(negedge clk);
    rdyrtn_n = 1'b1;
    @(negedge clk);
    access("R11 after return", 32'h1400_0020, 1'b1, 4'h0, 0, 1, 5'b00001, 19'h8, 4'hF, 0);
  endtask

  initial begin
    do_reset(4'b0101, 3'b101);
    chk(ldev_n && !ldev_oe, "R1 idle after reset", {30'd0, ldev_n, ldev_oe}, 2);
    access("R4 frame0 read", 32'h1400_1237, 0, 4'h0, 32'hDEAD_BEEF, 1, 5'b00001, 19'h48D, 4'hF, 32'hDEAD_BEEF);
    access("R4 frame1 write", 32'h1410_0008, 1, 4'b1100, 0, 1, 5'b00001, 19'h40002, 4'b0011, 0);
    access("R5 mio read lane2", 32'h1480_2000, 0, 4'h0, 32'h1122_3344, 1, 5'b00010, 19'h800, 4'b0100, 32'h0022_0000);
    access("R5 mio read lane0", 32'h1480_0004, 0, 4'h0, 32'h1122_3344, 1, 5'b00010, 19'h1, 4'b0001, 32'h0000_0044);
    access("R5 mio write", 32'h1480_3000, 1, 4'b0110, 0, 1, 5'b00010, 19'hC00, 4'b1001, 0);
    access("R6 port", 32'h148B_D404, 0, 4'h0, 32'hA5A5_0001, 1, 5'b00100, 19'h501, 4'hF, 32'hA5A5_0001);
    access("R6 tv", 32'h148A_EC10, 1, 4'h0, 0, 1, 5'b01000, 19'h104, 4'hF, 0);
    access("R6 cop", 32'h148A_F0FC, 0, 4'h0, 32'h0BAD_F00D, 1, 5'b10000, 19'h3F, 4'hF, 32'h0BAD_F00D);
    access("R6 cop misaligned", 32'h148A_F0FD, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    access("R2 wrong base", 32'h1800_0000, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    access("R2 bit31 set", 32'h9400_0000, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    access("R2 bit24 set", 32'h1500_0000, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    access("R7 hole", 32'h1440_0000, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    access("R7 next after miss", 32'h1400_0004, 1, 4'h0, 0, 1, 5'b00001, 19'h1, 4'hF, 0);
    t_hold();
    do_reset(4'b0101, 3'b100);
    access("R3 standard mode", 32'h1400_0000, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    do_reset(4'b0011, 3'b101);
    access("R2 relocated base", 32'h0C00_0040, 0, 4'h0, 32'h0000_CAFE, 1, 5'b00001, 19'h10, 4'hF, 32'h0000_CAFE);
    access("R2 old base misses", 32'h1400_0040, 0, 4'h0, 0, 0, 0, 0, 0, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule